// File: doc/BRIEF.md
# Legacy Memory Window Decoder

This block sits in a host bridge and decides where each access below 1 MB goes. It keeps the shadow-attribute configuration for the system BIOS area and for twelve 16 KB option-ROM areas, along with the system-management RAM control byte. For every memory address it receives, together with the access direction and an SMM flag, it returns one of three routes: main RAM, the I/O bus, or the protected SMM copy of the 0xA0000 video window.

Configuration arrives as dword writes with byte-lane enables, addressed by dword index in config space. The bytes are stored as soon as they are written. The decoding tables are refreshed only when a write lands on one of the attribute bytes or on the SMM control byte, and that refresh takes one extra clock. The route output is combinational from the current address and the active tables.

Top module: `legwin_decoder`

## Requirements
- R1: After reset every attribute field is 0 and the SMM control byte holds 0x02. Every access in 0xA0000..0xFFFFF then routes to the bus, with or without SMM.
- R2: Any address below 0xA0000 routes to RAM, whatever the configuration, direction or SMM flag.
- R3: Region 0 covers 0xF0000..0xFFFFF. Region j (1..12) covers the 16 KB starting at 0xC0000 + (j-1)*0x4000, so 0xEFFFF lies in region 12 and 0xF0000 lies in region 0.
- R4: Region i takes its field from config byte 0x59 + (i+1)/2. Odd regions use bits [1:0] of that byte. Region 0 and the even regions use bits [5:4]. Within a field, bit 0 set sends reads to RAM and bit 1 set sends writes to RAM. A clear bit sends that direction to the bus.
- R5: Bits [3:0] of byte 0x59 and bits 2, 3, 6 and 7 of the attribute bytes have no effect on any route.
- R6: In 0xA0000..0xBFFFF, an access that does not take the SMM path (see R7) goes to RAM when bit 6 (window open) of byte 0x72 is set, and to the bus when it is clear.
- R7: An SMM access in 0xA0000..0xBFFFF routes to SMRAM when bit 3 (global SMRAM enable) of byte 0x72 is set. When that bit is clear, the access follows R6.
- R8: A write stores byte k of cfgWrData[8k+7:8k] into config offset cfgDwAddr*4+k, only for lanes whose enable bit is set. Writes to offsets other than 0x59..0x5F and 0x72 change no route.
- R9: After a write to a tracked byte in clock cycle n, the route still reflects the old setting through cycle n+1. The new setting shows from cycle n+2 on.
- R10: Route codes are 0 for RAM, 1 for the bus and 2 for SMRAM. Code 3 never appears.
- R11: Code 2 appears only for an SMM access inside 0xA0000..0xBFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Config write strobe, one cycle per write |
| cfgDwAddr | input | 6 | Config dword index |
| cfgByteEn | input | 4 | Byte-lane enables of the write |
| cfgWrData | input | 32 | Write data, lane k in bits 8k+7:8k |
| memAddr | input | 20 | Address of the access being routed |
| memWrite | input | 1 | 1 for a write access, 0 for a read |
| memSmm | input | 1 | Access is made in system-management mode |
| routeCode | output | 2 | 0 RAM, 1 bus, 2 SMRAM |

## Verification
The latency property assumes that the config write strobe is low throughout reset. It also assumes that the three access inputs change only between clock edges, so that a route change can be traced to the write two edges earlier. The bench meets both conditions by holding cfgWrEn low while rstN is low and by driving every input at the falling edge. It confines addresses to the 20-bit space below 1 MB. Its random phase writes only the two attribute dwords and the SMM dword, so a refresh follows almost every write.

// File: rtl/legwin_pkg.sv
package legwin_pkg;
  localparam int ADDR_W         = 20;
  localparam int NUM_REGIONS    = 13;
  localparam int NUM_ATTR_BYTES = 7;
  localparam int ATTR_BASE_OFS  = 'h59;
  localparam int SMRAM_OFS      = 'h72;
  localparam logic [7:0] SMRAM_RST = 8'h02;
  localparam int OPEN_BIT       = 6;
  localparam int GLOBAL_EN_BIT  = 3;
  localparam int WIN_BASE       = 'hA0000;
  localparam int WIN_SIZE       = 'h20000;
  localparam int EXP_BASE       = 'hC0000;
  localparam int EXP_SIZE       = 'h04000;
  localparam int BIOS_BASE      = 'hF0000;
  localparam int BIOS_SIZE      = 'h10000;

  typedef enum logic [1:0] {
    ROUTE_RAM   = 2'd0,
    ROUTE_BUS   = 2'd1,
    ROUTE_SMRAM = 2'd2
  } route_e;

  typedef struct packed {
    logic [NUM_ATTR_BYTES-1:0] attrWr;
    logic                      smramWr;
    logic                      refresh;
  } strobe_t;
endpackage

// File: rtl/legwin_ctrl.sv
module legwin_ctrl
  import legwin_pkg::*;
#(
  parameter int DW_ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [DW_ADDR_W-1:0] cfgDwAddr,
  input  logic [3:0]           cfgByteEn,
  output strobe_t              strobes
);
  logic [NUM_ATTR_BYTES-1:0] attrHit;
  logic smramHit;
  logic refreshQ;

  always_comb begin
    attrHit  = '0;
    smramHit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (cfgWrEn && cfgByteEn[k]) begin
        for (int b = 0; b < NUM_ATTR_BYTES; b++) begin
          if (int'(cfgDwAddr) * 4 + k == ATTR_BASE_OFS + b) attrHit[b] = 1'b1;
        end
        if (int'(cfgDwAddr) * 4 + k == SMRAM_OFS) smramHit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) refreshQ <= 1'b0;
    else       refreshQ <= (|attrHit) | smramHit;
  end

  assign strobes.attrWr  = attrHit;
  assign strobes.smramWr = smramHit;
  assign strobes.refresh = refreshQ;
endmodule

// File: rtl/legwin_dp.sv
module legwin_dp
  import legwin_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [31:0]       cfgWrData,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memWrite,
  input  logic              memSmm,
  output route_e            route
);
  localparam int SMRAM_LANE = SMRAM_OFS % 4;

  logic [1:0] attrCfg [NUM_REGIONS];
  logic [1:0] attrAct [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] regionHit;
  logic openCfg, globalCfg, openAct, globalAct;
  logic unusedBits;

  assign unusedBits = ^cfgWrData;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    localparam int BYTE_IDX = (i + 1) / 2;
    localparam int LANE     = (ATTR_BASE_OFS + BYTE_IDX) % 4;
    localparam int NIB_LSB  = (i % 2 == 1) ? 0 : 4;
    localparam int R_BASE   = (i == 0) ? BIOS_BASE : EXP_BASE + EXP_SIZE * (i - 1);
    localparam int R_SIZE   = (i == 0) ? BIOS_SIZE : EXP_SIZE;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        attrCfg[i] <= 2'b00;
        attrAct[i] <= 2'b00;
      end else begin
        if (strobes.attrWr[BYTE_IDX]) attrCfg[i] <= cfgWrData[8*LANE+NIB_LSB +: 2];
        if (strobes.refresh)          attrAct[i] <= attrCfg[i];
      end
    end

    assign regionHit[i] = (int'(memAddr) >= R_BASE) && (int'(memAddr) < R_BASE + R_SIZE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openCfg   <= SMRAM_RST[OPEN_BIT];
      globalCfg <= SMRAM_RST[GLOBAL_EN_BIT];
      openAct   <= SMRAM_RST[OPEN_BIT];
      globalAct <= SMRAM_RST[GLOBAL_EN_BIT];
    end else begin
      if (strobes.smramWr) begin
        openCfg   <= cfgWrData[8*SMRAM_LANE+OPEN_BIT];
        globalCfg <= cfgWrData[8*SMRAM_LANE+GLOBAL_EN_BIT];
      end
      if (strobes.refresh) begin
        openAct   <= openCfg;
        globalAct <= globalCfg;
      end
    end
  end

  logic       winHit;
  logic       anyHit;
  logic [1:0] selAttr;

  always_comb begin
    winHit  = (int'(memAddr) >= WIN_BASE) && (int'(memAddr) < WIN_BASE + WIN_SIZE);
    anyHit  = 1'b0;
    selAttr = 2'b00;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (regionHit[i]) begin
        anyHit  = 1'b1;
        selAttr = attrAct[i];
      end
    end
    if (winHit) begin
      if (memSmm && globalAct) route = ROUTE_SMRAM;
      else if (openAct)        route = ROUTE_RAM;
      else                     route = ROUTE_BUS;
    end else if (anyHit) begin
      route = (memWrite ? selAttr[1] : selAttr[0]) ? ROUTE_RAM : ROUTE_BUS;
    end else begin
      route = ROUTE_RAM;
    end
  end
endmodule

// File: rtl/legwin_decoder.sv
module legwin_decoder
  import legwin_pkg::*;
#(
  parameter int DW_ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [DW_ADDR_W-1:0] cfgDwAddr,
  input  logic [3:0]           cfgByteEn,
  input  logic [31:0]          cfgWrData,
  input  logic [ADDR_W-1:0]    memAddr,
  input  logic                 memWrite,
  input  logic                 memSmm,
  output logic [1:0]           routeCode
);
  strobe_t strobes;
  route_e  route;

  legwin_ctrl #(.DW_ADDR_W(DW_ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgDwAddr(cfgDwAddr),
    .cfgByteEn(cfgByteEn), .strobes(strobes)
  );

  legwin_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWrData(cfgWrData),
    .memAddr(memAddr), .memWrite(memWrite), .memSmm(memSmm), .route(route)
  );

  assign routeCode = route;
endmodule

// File: rtl/legwin_chk.sv
module legwin_chk
  import legwin_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWrite,
  input logic              memSmm,
  input logic [1:0]        routeCode
);
  logic inWin;
  assign inWin = (int'(memAddr) >= WIN_BASE) && (int'(memAddr) < WIN_BASE + WIN_SIZE);

  AST_LOW_IS_RAM: assert property (@(posedge clk) disable iff (!rstN)
    (int'(memAddr) < WIN_BASE) |-> (routeCode == 2'd0)); // R2

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    routeCode != 2'd3); // R10

  AST_SMRAM_SCOPE: assert property (@(posedge clk) disable iff (!rstN)
    (routeCode == 2'd2) |-> (memSmm && inWin)); // R11

  AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cfgWrEn, 2) && $stable(memAddr) && $stable(memWrite) && $stable(memSmm))
      |-> $stable(routeCode)); // R9
endmodule

bind legwin_decoder legwin_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .memAddr(memAddr),
  .memWrite(memWrite), .memSmm(memSmm), .routeCode(routeCode)
);

// File: tb/tb_legwin_decoder.sv
`timescale 1ns/1ps
module tb_legwin_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [5:0]  cfgDwAddr = '0;
  logic [3:0]  cfgByteEn = '0;
  logic [31:0] cfgWrData = '0;
  logic [19:0] memAddr = '0;
  logic        memWrite = 1'b0;
  logic        memSmm = 1'b0;
  logic [1:0]  routeCode;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string curReq = "R1";

  int mCfg [256];
  int mAct [256];
  bit pend = 0;

  always #2.5 clk = ~clk;

  legwin_decoder dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgDwAddr(cfgDwAddr),
    .cfgByteEn(cfgByteEn), .cfgWrData(cfgWrData), .memAddr(memAddr),
    .memWrite(memWrite), .memSmm(memSmm), .routeCode(routeCode)
  );

  // Reference model: byte store plus one-edge-delayed active copy
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mCfg[i] = 0;
      mCfg['h72] = 2;
      mAct = mCfg;
      pend = 0;
    end else begin
      if (pend) mAct = mCfg;
      pend = 0;
      if (cfgWrEn) begin
        for (int k = 0; k < 4; k++) begin
          if (cfgByteEn[k]) begin
            int ofs;
            ofs = int'(cfgDwAddr) * 4 + k;
            mCfg[ofs] = int'(cfgWrData[8*k +: 8]);
            if ((ofs >= 'h59 && ofs <= 'h5F) || ofs == 'h72) pend = 1;
          end
        end
      end
    end
  end

  function automatic int expRoute(int a, bit w, bit s);
    int region, nib, ctl;
    if (a < 'hA0000) return 0;
    if (a < 'hC0000) begin
      ctl = mAct['h72];
      if (s && ((ctl >> 3) & 1) == 1) return 2;
      return (((ctl >> 6) & 1) == 1) ? 0 : 1;
    end
    region = (a >= 'hF0000) ? 0 : (a - 'hC0000) / 'h4000 + 1;
    nib = mAct['h59 + (region + 1) / 2];
    nib = (region % 2 == 1) ? (nib & 3) : ((nib >> 4) & 3);
    return (w ? ((nib >> 1) & 1) : (nib & 1)) == 1 ? 0 : 1;
  endfunction

  task automatic compareNow();
    int e;
    e = rstN ? expRoute(int'(memAddr), memWrite, memSmm) : -1;
    if (e >= 0) begin
      compared++;
      if (int'(routeCode) != e) begin
        mismatched++;
        $display("FAIL %s: model route=%0d expected=%0d addr=%h wr=%0b smm=%0b",
                 curReq, routeCode, e, memAddr, memWrite, memSmm);
      end
    end
  endtask

  task automatic lit(string req, int exp);
    compared++;
    if (int'(routeCode) != exp) begin
      mismatched++;
      $display("FAIL %s: route=%0d expected=%0d addr=%h wr=%0b smm=%0b",
               req, routeCode, exp, memAddr, memWrite, memSmm);
    end
  endtask

  task automatic drv(bit we, int dw, int be, int data, int a, bit w, bit s);
    @(negedge clk);
    cfgWrEn   = we;
    cfgDwAddr = 6'(dw);
    cfgByteEn = 4'(be);
    cfgWrData = 32'(data);
    memAddr   = 20'(a);
    memWrite  = w;
    memSmm    = s;
    #1;
    compareNow();
  endtask

  task automatic q(int a, bit w, bit s);
    drv(0, 0, 0, 0, a, w, s);
  endtask

  task automatic wrByte(int ofs, int val);
    drv(1, ofs / 4, 1 << (ofs % 4), val << (8 * (ofs % 4)), 0, 0, 0);
  endtask

  task automatic settle();
    q(0, 0, 0);
    q(0, 0, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: route=%0d expected=finished", routeCode);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    curReq = "R1";
    q('hF0000, 0, 0); lit("R1", 1);
    q('hC4000, 1, 0); lit("R1", 1);
    q('hA0000, 0, 0); lit("R1", 1);
    q('hBFFFF, 0, 1); lit("R1", 1);

    // R2 low memory
    curReq = "R2";
    q('h00000, 0, 0); lit("R2", 0);
    q('h9FFFF, 1, 1); lit("R2", 0);

    // R9 latency, with R4 region 0 read enable
    curReq = "R9";
    wrByte('h59, 'h10);
    q('hF0000, 0, 0); lit("R9", 1);
    q('hF0000, 0, 0); lit("R4", 0);
    q('hFFFFF, 1, 0); lit("R4", 1);

    // R5 unused bits
    curReq = "R5";
    wrByte('h59, 'h2F); settle();
    q('hF8000, 0, 0); lit("R5", 1);
    q('hF8000, 1, 0); lit("R5", 0);
    q('hC0000, 0, 0); lit("R5", 1);
    wrByte('h5A, 'hCC); settle();
    q('hC0000, 0, 0); lit("R5", 1);
    q('hC4000, 1, 0); lit("R5", 1);

    // R4 field positions, R3 boundaries
    curReq = "R4";
    wrByte('h5A, 'h21); settle();
    q('hC0000, 0, 0); lit("R4", 0);
    q('hC0000, 1, 0); lit("R4", 1);
    q('hC4000, 0, 0); lit("R4", 1);
    q('hC4000, 1, 0); lit("R4", 0);
    curReq = "R3";
    wrByte('h5F, 'h13); settle();
    q('hE8000, 1, 0); lit("R3", 0);
    q('hEBFFF, 0, 0); lit("R3", 0);
    q('hEC000, 1, 0); lit("R3", 1);
    q('hEFFFF, 0, 0); lit("R3", 0);
    q('hBFFFF, 0, 0); lit("R3", 1);
    q('hC3FFF, 0, 0); lit("R3", 0);

    // R8 byte lanes and ignored offsets
    curReq = "R8";
    drv(1, 'h17, 'b0100, 'h33221100, 0, 0, 0); settle();
    q('hE0000, 1, 0); lit("R8", 0);
    q('hE4000, 1, 0); lit("R8", 0);
    q('hE8000, 1, 0); lit("R8", 0);
    q('hEC000, 0, 0); lit("R8", 0);
    drv(1, 'h16, 'b0001, 'h000000FF, 0, 0, 0); settle();
    drv(1, 'h18, 'b1111, -1, 0, 0, 0); settle();
    q('hF0000, 0, 0); lit("R8", 1);
    q('hC0000, 1, 0); lit("R8", 1);

    // R6 window open
    curReq = "R6";
    wrByte('h72, 'h40); settle();
    q('hA0000, 0, 0); lit("R6", 0);
    q('hBFFFF, 1, 1); lit("R6", 0);
    // R7 global SMRAM enable
    curReq = "R7";
    wrByte('h72, 'h08);
    q('hA8000, 0, 1); lit("R9", 0);
    q('hA8000, 0, 1); lit("R7", 2);
    q('hA8000, 0, 0); lit("R7", 1);
    wrByte('h72, 'h48); settle();
    q('hB0000, 1, 1); lit("R7", 2);
    q('hB0000, 1, 0); lit("R7", 0);
    q('hC0000, 0, 1); lit("R11", 0);

    // R10 / R11 random traffic against the model
    curReq = "R10";
    seed = 12345;
    for (int n = 0; n < 400; n++) begin
      int a, sel;
      seed = seed * 1103515245 + 12345;
      a = (seed >>> 8) & 'hFFFFF;
      sel = (seed >>> 4) & 7;
      if (sel == 0)      drv(1, 'h16, (seed >>> 12) & 15, seed * 7, a, 0, 1);
      else if (sel == 1) drv(1, 'h17, (seed >>> 12) & 15, seed * 13, a, 1, 0);
      else if (sel == 2) drv(1, 'h1C, 4, seed, a, 0, 1);
      else               q(a, sel[0], sel[1]);
      if (routeCode == 2'd3) lit("R10", 0);
      if (routeCode == 2'd2 && !(memSmm && memAddr >= 20'hA0000 && memAddr < 20'hC0000))
        lit("R11", 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule